// File: doc/BRIEF.md
# Packed SIMD Integer Multiply-Subtract Unit

This block is one registered datapath that splits a vector into lanes. In each lane it multiplies two source elements and subtracts the product from the accumulator element in the same position. The same hardware handles 8-, 16- and 32-bit lanes. It works over either the low 64 bits of the vector or the full 128 bits.

Operands arrive together with a start strobe. The result and a done strobe appear on the next clock edge. The lane size and the vector length come from one of two places: direct control pins, or a 32-bit instruction word that the block decodes itself. An encoding the block does not support raises an undefined flag and returns the accumulator unchanged.

Top module: `lane_mls_top`

## Requirements
- R1: Each active lane of the result equals the accumulator lane minus the product of the two source lanes. Both the product and the difference keep only the low lane-width bits, so the arithmetic wraps modulo 2^width. No lane affects any other lane.
- R2: A size code selects the lane width: 0 selects 8 bits, 1 selects 16 bits and 2 selects 32 bits.
- R3: When the length select is 1, all 128 bits are processed. When it is 0, only bits 63:0 are processed, and bits 127:64 of the result equal the accumulator input.
- R4: `done_o` is high in exactly the cycle after a cycle in which `start_i` is high, and is low otherwise. A new start is accepted every cycle.
- R5: A size code of 3 sets `undef_o` together with `done_o`, and the result equals the accumulator input.
- R6: When `use_insn_i` is 1, the controls come from `insn_i`: size from bits 21:20 and length from bit 6. The word is accepted only if bits 31:25 are 1111001, bit 24 is 1, bit 23 is 0, bits 11:8 are 1001 and bit 4 is 0. Any other word sets `undef_o`. For example, 0xF3000940 is a 128-bit operation on byte lanes, and 0xF3000900 is a 64-bit one.
- R7: In decoded 128-bit mode, a 1 in bit 12, bit 16 or bit 0 of `insn_i` (an odd register index) sets `undef_o`. In 64-bit mode these bits have no effect.
- R8: `result_o` and `undef_o` change only in the cycle after a start. When `start_i` is low they hold their values.
- R9: After reset, `done_o`, `undef_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch an operation this cycle |
| use_insn_i | input | 1 | 1: take the controls from insn_i; 0: take them from the direct pins |
| insn_i | input | 32 | Instruction word to decode |
| size_i | input | 2 | Direct lane-size code |
| wide_i | input | 1 | Direct length select (1 = 128-bit) |
| acc_i | input | 128 | Accumulator vector |
| src_a_i | input | 128 | First multiplicand vector |
| src_b_i | input | 128 | Second multiplicand vector |
| result_o | output | 128 | Registered result |
| done_o | output | 1 | Result valid strobe |
| undef_o | output | 1 | Unsupported encoding flag |

## Verification
The operand table varies the values lane by lane, so that a lane-boundary error or a wrong width selection changes the bit pattern. It is run at all three lane widths and both vector lengths. Maximum-value operands subtracted from zero catch a missing wrap or a product truncated at the wrong width. Distinct upper-half accumulator data exposes any leak into bits 127:64 in 64-bit mode. Decoded words with one wrong fixed bit, size code 3, or an odd register index separate the undefined conditions from one another. Back-to-back starts show that the block has no hidden busy cycle.

// File: rtl/lane_mls_pkg.sv
package lane_mls_pkg;
    localparam int VEC_W  = 128;
    localparam int HALF_W = VEC_W / 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } lane_size_e;

    typedef struct packed {
        lane_size_e size;
        logic       wide;
        logic       undef;
    } mls_ctrl_t;

    function automatic logic fixed_bits_ok(input logic [31:0] w);
        return (w[31:25] == 7'b1111001) && w[24] && !w[23]
            && (w[11:8] == 4'b1001) && !w[4];
    endfunction

    function automatic logic odd_index(input logic [31:0] w);
        return w[12] | w[16] | w[0];
    endfunction
endpackage

// File: rtl/mls_decode.sv
module mls_decode
    import lane_mls_pkg::*;
(
    input  logic        use_insn_i,
    input  logic [31:0] insn_i,
    input  logic [1:0]  size_i,
    input  logic        wide_i,
    output mls_ctrl_t   ctrl_o
);
    logic [1:0] sz;
    logic       wd;
    logic       bad_word;

    always_comb begin
        if (use_insn_i) begin
            sz       = insn_i[21:20];
            wd       = insn_i[6];
            bad_word = !fixed_bits_ok(insn_i) || (wd && odd_index(insn_i));
        end else begin
            sz       = size_i;
            wd       = wide_i;
            bad_word = 1'b0;
        end
        ctrl_o.size  = lane_size_e'(sz);
        ctrl_o.wide  = wd;
        ctrl_o.undef = bad_word || (sz == SZ_BAD);
    end
endmodule

// File: rtl/mls_lanes.sv
module mls_lanes #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8
) (
    input  logic [VEC_W-1:0] acc_i,
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    output logic [VEC_W-1:0] res_o
);
    localparam int LANES = VEC_W / ELEM_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [ELEM_W-1:0] prod;
        assign prod = a_i[i*ELEM_W +: ELEM_W] * b_i[i*ELEM_W +: ELEM_W];
        assign res_o[i*ELEM_W +: ELEM_W] = acc_i[i*ELEM_W +: ELEM_W] - prod;
    end
endmodule

// File: rtl/lane_mls_top.sv
module lane_mls_top
    import lane_mls_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         use_insn_i,
    input  logic [31:0]  insn_i,
    input  logic [1:0]   size_i,
    input  logic         wide_i,
    input  logic [127:0] acc_i,
    input  logic [127:0] src_a_i,
    input  logic [127:0] src_b_i,
    output logic [127:0] result_o,
    output logic         done_o,
    output logic         undef_o
);
    mls_ctrl_t ctrl;
    logic [VEC_W-1:0] res_b, res_h, res_w, picked, next_res;

    mls_decode u_dec (
        .use_insn_i(use_insn_i), .insn_i(insn_i),
        .size_i(size_i), .wide_i(wide_i), .ctrl_o(ctrl)
    );

    mls_lanes #(.VEC_W(VEC_W), .ELEM_W(8))  u_b (.acc_i(acc_i), .a_i(src_a_i), .b_i(src_b_i), .res_o(res_b));
    mls_lanes #(.VEC_W(VEC_W), .ELEM_W(16)) u_h (.acc_i(acc_i), .a_i(src_a_i), .b_i(src_b_i), .res_o(res_h));
    mls_lanes #(.VEC_W(VEC_W), .ELEM_W(32)) u_w (.acc_i(acc_i), .a_i(src_a_i), .b_i(src_b_i), .res_o(res_w));

    always_comb begin
        unique case (ctrl.size)
            SZ_BYTE: picked = res_b;
            SZ_HALF: picked = res_h;
            SZ_WORD: picked = res_w;
            default: picked = acc_i;
        endcase
        if (ctrl.undef)
            next_res = acc_i;
        else if (!ctrl.wide)
            next_res = {acc_i[VEC_W-1:HALF_W], picked[HALF_W-1:0]};
        else
            next_res = picked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            done_o   <= 1'b0;
            undef_o  <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                result_o <= next_res;
                undef_o  <= ctrl.undef;
            end
        end
    end
endmodule

// File: rtl/lane_mls_checker.sv
module lane_mls_checker (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         use_insn_i,
    input logic [31:0]  insn_i,
    input logic [1:0]   size_i,
    input logic         wide_i,
    input logic [127:0] acc_i,
    input logic [127:0] result_o,
    input logic         done_o,
    input logic         undef_o
);
    // R4
    a_r4_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);
    a_r4_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !done_o);
    // R5
    a_r5_bad_size_flags: assert property (@(posedge clk) disable iff (rst)
        (start_i && !use_insn_i && size_i == 2'd3) |=> (undef_o && result_o == $past(acc_i)));
    a_r5_good_size_clean: assert property (@(posedge clk) disable iff (rst)
        (start_i && !use_insn_i && size_i != 2'd3) |=> !undef_o);
    // R3
    a_r3_upper_passthrough: assert property (@(posedge clk) disable iff (rst)
        (start_i && ((!use_insn_i && !wide_i) || (use_insn_i && !insn_i[6])))
        |=> result_o[127:64] == $past(acc_i[127:64]));
    // R8
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(result_o) && $stable(undef_o)));
endmodule

bind lane_mls_top lane_mls_checker u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .use_insn_i(use_insn_i),
    .insn_i(insn_i), .size_i(size_i), .wide_i(wide_i), .acc_i(acc_i),
    .result_o(result_o), .done_o(done_o), .undef_o(undef_o)
);

// File: tb/tb_lane_mls_top.sv
module tb_lane_mls_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         start_i, use_insn_i, wide_i;
    logic [31:0]  insn_i;
    logic [1:0]   size_i;
    logic [127:0] acc_i, src_a_i, src_b_i;
    logic [127:0] result_o;
    logic         done_o, undef_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    lane_mls_top dut (.*);

    localparam int NV = 4;
    localparam logic [127:0] T_ACC[NV] = '{
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
        128'h0,
        128'hDEAD_BEEF_0000_FFFF_1234_8000_7FFF_0001,
        128'h8000_0000_7FFF_FFFF_0000_0001_FFFF_FFFE};
    localparam logic [127:0] T_A[NV] = '{
        128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'h1357_9BDF_2468_ACE0_0F0F_F0F0_55AA_AA55,
        128'h0000_0002_FFFF_0003_8000_0000_0001_0001};
    localparam logic [127:0] T_B[NV] = '{
        128'h1111_2222_3333_4444_5555_6666_7777_8888,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'hFEDC_BA98_0123_4567_89AB_CDEF_0F1E_2D3C,
        128'h4000_0000_0002_0005_0000_0002_FFFF_FFFF};

    function automatic logic [127:0] ref_mls(input logic [127:0] acc, a, b,
                                             input int w, input bit wide);
        logic [127:0] r = acc;
        longint unsigned mask = (w == 32) ? 64'hFFFF_FFFF : ((64'd1 << w) - 1);
        int n = (wide ? 128 : 64) / w;
        for (int i = 0; i < n; i++) begin
            longint unsigned x = 64'(acc >> (i*w)) & mask;
            longint unsigned y = 64'(a >> (i*w)) & mask;
            longint unsigned z = 64'(b >> (i*w)) & mask;
            longint unsigned d = (x - y*z) & mask;
            r = (r & ~({64'd0, mask} << (i*w))) | ({64'd0, d} << (i*w));
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one operation: drive at negedge, sample at the following negedge
    task automatic run_op(input bit ui, input logic [31:0] iw, input logic [1:0] sz,
                          input bit wd, input logic [127:0] acc, a, b);
        @(negedge clk);
        start_i = 1'b1; use_insn_i = ui; insn_i = iw; size_i = sz; wide_i = wd;
        acc_i = acc; src_a_i = a; src_b_i = b;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; start_i = 0; use_insn_i = 0; insn_i = '0; size_i = '0; wide_i = 0;
        acc_i = '0; src_a_i = '0; src_b_i = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(done_o == 0 && undef_o == 0 && result_o == '0, "R9", result_o, '0);
        rst = 1'b0;

        // table walk: R1 R2 R3 over all widths and lengths
        for (int v = 0; v < NV; v++) begin
            for (int s = 0; s < 3; s++) begin
                for (int q = 0; q < 2; q++) begin
                    logic [127:0] exp;
                    exp = ref_mls(T_ACC[v], T_A[v], T_B[v], 8 << s, q[0]);
                    run_op(0, '0, 2'(s), q[0], T_ACC[v], T_A[v], T_B[v]);
                    check(done_o && !undef_o && result_o == exp,
                          q ? "R1/R2 wide" : "R3 narrow", result_o, exp);
                end
            end
        end

        // R1 wrap: max product from zero, 32-bit lanes give all ones
        run_op(0, '0, 2'd2, 1, '0, {128{1'b1}}, {128{1'b1}});
        check(result_o == {128{1'b1}}, "R1 wrap", result_o, {128{1'b1}});

        // R3 upper passthrough with distinct upper data
        run_op(0, '0, 2'd0, 0, 128'hAAAA_BBBB_CCCC_DDDD_0000_0000_0000_0000,
               {128{1'b1}}, {128{1'b1}});
        check(result_o == 128'hAAAA_BBBB_CCCC_DDDD_FFFF_FFFF_FFFF_FFFF, "R3 upper",
              result_o, 128'hAAAA_BBBB_CCCC_DDDD_FFFF_FFFF_FFFF_FFFF);

        // R5 size 3
        run_op(0, '0, 2'd3, 1, T_ACC[0], T_A[0], T_B[0]);
        check(done_o && undef_o && result_o == T_ACC[0], "R5", result_o, T_ACC[0]);

        // R8 hold while idle
        @(negedge clk);
        check(!done_o && undef_o && result_o == T_ACC[0], "R8/R4 idle", result_o, T_ACC[0]);

        // R6 decoded 128-bit halfword
        run_op(1, 32'hF310_0940, 2'd3, 0, T_ACC[2], T_A[2], T_B[2]);
        check(!undef_o && result_o == ref_mls(T_ACC[2], T_A[2], T_B[2], 16, 1), "R6 wide",
              result_o, ref_mls(T_ACC[2], T_A[2], T_B[2], 16, 1));
        // R6 decoded 64-bit word
        run_op(1, 32'hF320_0900, 2'd0, 1, T_ACC[3], T_A[3], T_B[3]);
        check(!undef_o && result_o == ref_mls(T_ACC[3], T_A[3], T_B[3], 32, 0), "R6 narrow",
              result_o, ref_mls(T_ACC[3], T_A[3], T_B[3], 32, 0));
        // R6 bad fixed bit (bit 4 set)
        run_op(1, 32'hF300_0950, 2'd0, 1, T_ACC[1], T_A[0], T_B[0]);
        check(undef_o && result_o == T_ACC[1], "R6 badbit", result_o, T_ACC[1]);
        // R6 decoded size 3 (R5 via insn)
        run_op(1, 32'hF330_0940, 2'd0, 1, T_ACC[0], T_A[0], T_B[0]);
        check(undef_o && result_o == T_ACC[0], "R5 insn", result_o, T_ACC[0]);

        // R7 odd index in wide mode, each field
        run_op(1, 32'hF300_1940, 2'd0, 1, T_ACC[2], T_A[0], T_B[0]);
        check(undef_o && result_o == T_ACC[2], "R7 vd", result_o, T_ACC[2]);
        run_op(1, 32'hF301_0940, 2'd0, 1, T_ACC[3], T_A[0], T_B[0]);
        check(undef_o && result_o == T_ACC[3], "R7 vn", result_o, T_ACC[3]);
        run_op(1, 32'hF300_0941, 2'd0, 1, T_ACC[0], T_A[0], T_B[0]);
        check(undef_o && result_o == T_ACC[0], "R7 vm", result_o, T_ACC[0]);
        // R7 odd indices allowed in narrow mode
        run_op(1, 32'hF301_1901, 2'd3, 1, T_ACC[0], T_A[0], T_B[0]);
        check(!undef_o && result_o == ref_mls(T_ACC[0], T_A[0], T_B[0], 8, 0), "R7 narrow",
              result_o, ref_mls(T_ACC[0], T_A[0], T_B[0], 8, 0));

        // R4 back-to-back starts
        @(negedge clk);
        start_i = 1; use_insn_i = 0; size_i = 2'd1; wide_i = 1;
        acc_i = T_ACC[0]; src_a_i = T_A[0]; src_b_i = T_B[0];
        @(negedge clk);
        check(done_o && result_o == ref_mls(T_ACC[0], T_A[0], T_B[0], 16, 1), "R4 first",
              result_o, ref_mls(T_ACC[0], T_A[0], T_B[0], 16, 1));
        acc_i = T_ACC[2]; src_a_i = T_A[2]; src_b_i = T_B[2]; size_i = 2'd0;
        @(negedge clk);
        start_i = 0;
        check(done_o && result_o == ref_mls(T_ACC[2], T_A[2], T_B[2], 8, 1), "R4 second",
              result_o, ref_mls(T_ACC[2], T_A[2], T_B[2], 8, 1));
        @(negedge clk);
        check(!done_o, "R4 drop", {127'd0, done_o}, '0);

        // R9 reset again
        rst = 1;
        @(negedge clk);
        check(!done_o && !undef_o && result_o == '0, "R9 rereset", result_o, '0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule